// File: doc/BRIEF.md
# DES Key Setup Unit

This block performs the first step of the DES key schedule on a 64-bit key that sits in two 32-bit working registers. The upper word carries key bits 1 to 32 and the lower word carries bits 33 to 64. DES numbering is used throughout, so bit 1 is the most significant bit of the upper word. On a command strobe the block applies the permuted-choice-1 bit selection. This drops the eight parity bits and yields two 28-bit halves, C and D. Each half is written back, left-justified, into the word it came from.

One control flag picks the decryption form or the encryption form. The decryption form writes the halves unchanged as C0/D0. The encryption form rotates each half left by one place and writes C1/D1. A second flag enables an odd-parity check over the eight key bytes. The result of that check is kept in a status bit until the next command.

The result and the status bit appear one clock after the strobe. A single-cycle done pulse marks that cycle. Commands may be issued on consecutive cycles.

Top module: `des_key_setup`

## Requirements
- R1: Output word 0 bits 31..4 hold C, where C bit k (k = 1..28, bit 1 at word bit 31) is the key bit that permuted choice 1 selects for position k. The key is {word0, word1} with DES bit n at vector index 64-n. C's sources are 57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36.
- R2: Output word 1 bits 31..4 hold D, built the same way. D's sources are 63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4.
- R3: With the decrypt flag at 1, C and D are written with no rotation (C0/D0).
- R4: With the decrypt flag at 0, each 28-bit half is rotated left by one place inside the half: the old bit 1 moves to bit 28 (C1/D1).
- R5: Bits 3..0 of both output words are written as zero on every command.
- R6: With the parity flag at 1 and at least one key byte holding an even number of ones, the error bit is set to 1.
- R7: With the parity flag at 0, the command clears the error bit whatever the key.
- R8: With the parity flag at 1 and every key byte of odd weight, the command clears the error bit.
- R9: Results and the error bit update at the clock edge after the one that samples the strobe. Done is high for exactly that one cycle per strobe cycle, and never without a strobe.
- R10: Without a strobe, both output words and the error bit hold their values whatever the key and flag inputs do.
- R11: Under synchronous active-low reset, both output words, done and the error bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command strobe, one command per high cycle |
| decrypt_i | input | 1 | 1: unrotated halves, 0: halves rotated once |
| chk_par_i | input | 1 | 1: run the key odd-parity check |
| key_w0_i | input | 32 | Key bits 1..32 (bit 1 at index 31) |
| key_w1_i | input | 32 | Key bits 33..64 (bit 33 at index 31) |
| key_w0_o | output | 32 | C half, left-justified, low nibble zero |
| key_w1_o | output | 32 | D half, left-justified, low nibble zero |
| done_o | output | 1 | One-cycle pulse when the results update |
| par_err_o | output | 1 | Key parity error status |

## Verification
The cipher fixes the geometry, so the bench builds the block with the package defaults: 32-bit words, 28-bit halves and eight 8-bit parity bytes. With these values a walk of a single set bit through all 64 key positions, in both rotation modes, reaches every permutation wire. It also reaches the wrap of the rotation at each half's end and the eight dropped parity positions. Keys of all zeros, all ones and mixed byte weights reach each parity outcome under both settings of the parity flag. Strobes on consecutive cycles and idle stretches with changing inputs reach the pulse and hold timing.

// File: rtl/des_ks_pkg.sv
// Package: shared widths and the permuted-choice-1 source table.
// Assumes DES bit numbering: bit 1 is the MSB of the 64-bit key.
package des_ks_pkg;
    localparam int KEY_W   = 64;
    localparam int WORD_W  = KEY_W / 2;
    localparam int HALF_W  = 28;
    localparam int PAD_W   = WORD_W - HALF_W;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = KEY_W / BYTE_W;
    localparam int PC1_N   = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    // Returns the DES key bit number feeding output position idx (0..55, C then D).
    function automatic int pc1_src(input int idx);
        case (idx)
            0:  return 57;  1:  return 49;  2:  return 41;  3:  return 33;
            4:  return 25;  5:  return 17;  6:  return 9;   7:  return 1;
            8:  return 58;  9:  return 50;  10: return 42;  11: return 34;
            12: return 26;  13: return 18;  14: return 10;  15: return 2;
            16: return 59;  17: return 51;  18: return 43;  19: return 35;
            20: return 27;  21: return 19;  22: return 11;  23: return 3;
            24: return 60;  25: return 52;  26: return 44;  27: return 36;
            28: return 63;  29: return 55;  30: return 47;  31: return 39;
            32: return 31;  33: return 23;  34: return 15;  35: return 7;
            36: return 62;  37: return 54;  38: return 46;  39: return 38;
            40: return 30;  41: return 22;  42: return 14;  43: return 6;
            44: return 61;  45: return 53;  46: return 45;  47: return 37;
            48: return 29;  49: return 21;  50: return 13;  51: return 5;
            52: return 28;  53: return 20;  54: return 12;  55: return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/des_pc1_perm.sv
// Module: fixed-wire permuted choice 1. Splits a 64-bit key into C and D halves.
// Assumes key_i[KEY_W-n] carries DES bit n; output bit HALF_W-1 is half position 1.
module des_pc1_perm
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output half_t            c_o,
    output half_t            d_o
);
    // One wire per selected key bit; the table decides the source index.
    for (genvar i = 0; i < PC1_N; i++) begin : g_sel
        localparam int SRC = KEY_W - pc1_src(i);
        if (i < HALF_W) begin : g_c
            assign c_o[HALF_W-1-i] = key_i[SRC];
        end else begin : g_d
            assign d_o[PC1_N-1-i] = key_i[SRC];
        end
    end
endmodule

// File: rtl/des_half_rotl.sv
// Module: optional one-place circular left rotation of a key half.
// Assumes W >= 2; bypass_i = 1 passes the half unchanged.
module des_half_rotl #(
    parameter int W = 28
) (
    input  logic [W-1:0] half_i,
    input  logic         bypass_i,
    output logic [W-1:0] half_o
);
    logic [W-1:0] rot;

    // Rotation wraps the MSB into the LSB.
    assign rot = {half_i[W-2:0], half_i[W-1]};

    // Select unrotated or rotated half.
    always_comb begin
        half_o = bypass_i ? half_i : rot;
    end
endmodule

// File: rtl/des_odd_parity.sv
// Module: DES odd-parity checker over all key bytes.
// Assumes each byte must carry an odd count of ones; bad_o flags any failing byte.
module des_odd_parity
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic             bad_o
);
    logic [N_BYTES-1:0] byte_bad;

    // A byte fails when its XOR reduction is zero (even weight).
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign byte_bad[b] = ~(^key_i[b*BYTE_W +: BYTE_W]);
    end

    // Any failing byte raises the flag.
    always_comb begin
        bad_o = |byte_bad;
    end
endmodule

// File: rtl/des_key_setup.sv
// Module: DES key setup top. Applies PC-1, optionally rotates each half once,
// checks key parity on request and registers the results one clock after the strobe.
// Assumes the key words are stable in the strobe cycle; reset is synchronous, active low.
module des_key_setup
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              decrypt_i,
    input  logic              chk_par_i,
    input  logic [WORD_W-1:0] key_w0_i,
    input  logic [WORD_W-1:0] key_w1_i,
    output logic [WORD_W-1:0] key_w0_o,
    output logic [WORD_W-1:0] key_w1_o,
    output logic              done_o,
    output logic              par_err_o
);
    logic [KEY_W-1:0] key_all;
    half_t            c_raw, d_raw, c_sel, d_sel;
    logic             par_bad;
    word_t            w0_q, w1_q;
    logic             done_q, err_q;

    assign key_all = {key_w0_i, key_w1_i};

    des_pc1_perm u_perm (
        .key_i (key_all),
        .c_o   (c_raw),
        .d_o   (d_raw)
    );

    des_half_rotl #(.W(HALF_W)) u_rot_c (
        .half_i   (c_raw),
        .bypass_i (decrypt_i),
        .half_o   (c_sel)
    );

    des_half_rotl #(.W(HALF_W)) u_rot_d (
        .half_i   (d_raw),
        .bypass_i (decrypt_i),
        .half_o   (d_sel)
    );

    des_odd_parity u_par (
        .key_i (key_all),
        .bad_o (par_bad)
    );

    // Capture results and status on a strobe; pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q   <= '0;
            w1_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                w0_q  <= {c_sel, {PAD_W{1'b0}}};
                w1_q  <= {d_sel, {PAD_W{1'b0}}};
                err_q <= chk_par_i & par_bad;
            end
        end
    end

    assign key_w0_o  = w0_q;
    assign key_w1_o  = w1_q;
    assign done_o    = done_q;
    assign par_err_o = err_q;
endmodule

// File: rtl/des_key_setup_chk.sv
// Module: property checker for des_key_setup, attached by bind.
// Assumes it sees the top-level ports only.
module des_key_setup_chk
    import des_ks_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              decrypt_i,
    input logic              chk_par_i,
    input logic [WORD_W-1:0] key_w0_i,
    input logic [WORD_W-1:0] key_w1_i,
    input logic [WORD_W-1:0] key_w0_o,
    input logic [WORD_W-1:0] key_w1_o,
    input logic              done_o,
    input logic              par_err_o
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R9
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R9
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (key_w0_o[PAD_W-1:0] == '0 && key_w1_o[PAD_W-1:0] == '0)); // R5
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(key_w0_o) && $stable(key_w1_o) && $stable(par_err_o))); // R10
    AST_ERR_CLEAR_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !chk_par_i) |=> !par_err_o); // R7
    AST_DECRYPT_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && decrypt_i) |=> key_w0_o[WORD_W-1] == $past(key_w1_i[7])); // R3
    AST_ENCRYPT_ROT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !decrypt_i) |=> (key_w0_o[WORD_W-1] == $past(key_w1_i[15])
                                     && key_w0_o[PAD_W] == $past(key_w1_i[7]))); // R4
endmodule

bind des_key_setup des_key_setup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .decrypt_i (decrypt_i),
    .chk_par_i (chk_par_i),
    .key_w0_i  (key_w0_i),
    .key_w1_i  (key_w1_i),
    .key_w0_o  (key_w0_o),
    .key_w1_o  (key_w1_o),
    .done_o    (done_o),
    .par_err_o (par_err_o)
);

// File: tb/des_key_setup_tb_top.sv
// Bench: scoreboard for des_key_setup. A driver task pushes expected results,
// a monitor at the falling edge pops and compares them whenever done is seen.
module des_key_setup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        decrypt_i = 1'b0;
    logic        chk_par_i = 1'b0;
    logic [31:0] key_w0_i = '0;
    logic [31:0] key_w1_i = '0;
    logic [31:0] key_w0_o, key_w1_o;
    logic        done_o, par_err_o;

    typedef struct {
        logic [31:0] w0;
        logic [31:0] w1;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_on = 1'b0;
    logic [63:0] lfsr = 64'h0123_4567_89AB_CDEF;

    always #5 clk = ~clk;

    des_key_setup dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
        .chk_par_i(chk_par_i), .key_w0_i(key_w0_i), .key_w1_i(key_w1_i),
        .key_w0_o(key_w0_o), .key_w1_o(key_w1_o), .done_o(done_o), .par_err_o(par_err_o)
    );

    // Counts one check and reports a miscompare.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements (PC-1 sources by formula).
    function automatic exp_t model(input logic [31:0] k0, input logic [31:0] k1,
                                   input logic dc, input logic cp, input string tag);
        exp_t        e;
        logic [63:0] k;
        logic [27:0] c, d;
        bit          bad;
        int          sc, sd;
        k = {k0, k1};
        for (int i = 0; i < 28; i++) begin
            sc = 57 + i / 8 - 8 * (i % 8);
            sd = (i < 24) ? (63 - i / 8 - 8 * (i % 8)) : (28 - 8 * (i % 8));
            c[27-i] = k[64-sc];
            d[27-i] = k[64-sd];
        end
        if (!dc) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
        end
        bad = 1'b0;
        for (int b = 0; b < 8; b++) begin
            if ($countones(k[b*8 +: 8]) % 2 == 0) bad = 1'b1;
        end
        e.w0  = {c, 4'h0};
        e.w1  = {d, 4'h0};
        e.err = cp & bad;
        e.tag = tag;
        return e;
    endfunction

    // Driver: strobe one command for one cycle and queue its expected result.
    task automatic send(input logic [31:0] k0, input logic [31:0] k1,
                        input logic dc, input logic cp, input string tag);
        key_w0_i  = k0;
        key_w1_i  = k1;
        decrypt_i = dc;
        chk_par_i = cp;
        start_i   = 1'b1;
        sb.push_back(model(k0, k1, dc, cp, tag));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        start_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each done cycle with the oldest expected item.
    always @(negedge clk) begin
        if (mon_on && done_o) begin
            if (sb.size() == 0) begin
                check("R9 spurious done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " word0"}, key_w0_o, e.w0);
                check({e.tag, " word1"}, key_w1_o, e.w1);
                check({e.tag, " err"}, {31'd0, par_err_o}, {31'd0, e.err});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] h0, h1;
        logic        he;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 word0", key_w0_o, 32'h0);
        check("R11 word1", key_w1_o, 32'h0);
        check("R11 done/err", {30'd0, done_o, par_err_o}, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R8: known key, no rotation, good parity
        send(32'h1334_5779, 32'h9BBC_DFF1, 1'b1, 1'b1, "R1/R2/R3/R8 known key");
        check("R1 literal C0", 32'hF0CC_AAF0, model(32'h1334_5779, 32'h9BBC_DFF1, 1, 1, "").w0);
        // R4: known key, rotated
        send(32'h1334_5779, 32'h9BBC_DFF1, 1'b0, 1'b1, "R4 known key rot");
        check("R4 literal D1", 32'hAACC_F1E0, model(32'h1334_5779, 32'h9BBC_DFF1, 0, 1, "").w1);
        // R6 / R7: all-zero key has even bytes
        send(32'h0, 32'h0, 1'b0, 1'b1, "R6 zero key");
        send(32'h0, 32'h0, 1'b0, 1'b0, "R7 zero key");
        // R5 / R6: all ones, halves full
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, "R5/R6 ones key");
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5/R7 ones key");
        idle(2);

        // R1 R2 R3 R4: walking single bit in both modes, back to back
        for (int n = 0; n < 64; n++) begin
            logic [63:0] kk;
            kk = 64'd1 << n;
            send(kk[63:32], kk[31:0], 1'b1, n[0], "R1/R2/R3 walk");
            send(kk[63:32], kk[31:0], 1'b0, n[1], "R1/R2/R4 walk");
        end
        idle(2);

        // R6 R8: pseudo-random keys, with odd-parity fixes on half of them
        for (int j = 0; j < 40; j++) begin
            logic [63:0] kk;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            kk = lfsr;
            if (j[0]) begin
                for (int b = 0; b < 8; b++)
                    kk[b*8] = ~(^kk[b*8+1 +: 7]);
            end
            send(kk[63:32], kk[31:0], j[1], 1'b1, "R6/R8 random");
            if (j[2]) idle(1);
        end
        idle(3);
        check("R9 pending results", sb.size(), 32'd0);

        // R10: inputs change without a strobe, outputs hold
        h0 = key_w0_o;
        h1 = key_w1_o;
        he = par_err_o;
        for (int t = 0; t < 4; t++) begin
            key_w0_i  = 32'hA5A5_0000 + t;
            key_w1_i  = ~key_w0_i;
            decrypt_i = t[0];
            chk_par_i = ~t[0];
            @(negedge clk);
            check("R10 hold word0", key_w0_o, h0);
            check("R10 hold word1", key_w1_o, h1);
            check("R10 hold err/done", {30'd0, done_o, par_err_o}, {30'd0, 1'b0, he});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule